// File: doc/BRIEF.md
# Synchronous Card Bit-Frame Sequencer

This block runs the clock and data lines of a synchronous memory card. A divided system clock becomes the card clock, and every card clock period moves one bit. Bits go out from a small transmit queue, or come in and are collected into a receive queue, least significant bit first. Outgoing bits change on the falling card edge. Incoming bits are sampled on the rising card edge.

A reloadable length counter marks the bounds of each frame. When the last bit of a frame is done, it raises a sticky interrupt. Outside a frame, software owns the line. It can hold the card clock at a chosen level, and in transmit mode it drives the data line from a data bit and a direction bit. A start condition and a stop condition are built from these controls between frames. In the optional two-wire mode, the last bit of a frame is an acknowledge that flows against the data direction.

Top module: `sync_card_sequencer`

## Requirements
- R1: While reset is held: card_clk_o is 0, irq_o is 0, io_oe_o is 0 (with tx_mode_i low), rx_empty_o is 1, tx_full_o is 0 and ack_o is 1.
- R2: With clk_stop_i low, card_clk_o is a square wave with a period of 2*(div_i+1) system clocks.
- R3: One cycle after clk_stop_i is sampled high, card_clk_o equals stop_lvl_i and holds there. After release, the first transition comes div_i+1 system clocks later.
- R4: In transmit mode (tx_mode_i=1), software owns the line in two cases: from a reload until the first falling card edge, and once the count reaches the length. While software owns it, io_o follows sw_io_i and io_oe_o follows sw_dir_i (1 = drive).
- R5: A transmit frame of length L puts L bits on io_o with io_oe_o=1. Each bit is valid at its rising card edge. The bits are queued bytes taken least significant bit first, and a frame may run on into the next byte.
- R6: irq_o rises at the falling card edge that follows the last bit of a frame. It stays high until an irq_clr_i pulse clears it. A new set wins over a clear in the same cycle.
- R7: In receive mode (tx_mode_i=0), io_oe_o is 0 on data slots and outside frames. io_i is sampled at each rising card edge. Every 8 bits form a byte, least significant bit first, and the byte is pushed to the receive queue. rx_data_o shows the oldest byte, and rx_rd_i removes it.
- R8: In two-wire transmit mode, slot L-1 (counted from 0) is not driven (io_oe_o=0). io_i sampled at its rising edge appears on ack_o. Slots 0 to L-2 carry queue data.
- R9: In two-wire receive mode, slot L-1 drives io_o=0 with io_oe_o=1 as the acknowledge. The bit in that slot is not stored.
- R10: A reload in the middle of a frame restarts counting and returns the line to software. The next frame runs its full new length and starts on a fresh queue byte.
- R11: When the transmit queue is empty at the start of a byte, that byte goes out as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Half-period of the card clock, minus one, in system clocks |
| clk_stop_i | input | 1 | Freeze the card clock |
| stop_lvl_i | input | 1 | Level of the frozen card clock |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| twowire_i | input | 1 | Last slot of a frame is an acknowledge |
| sw_io_i | input | 1 | Software data bit for the line |
| sw_dir_i | input | 1 | Software direction bit, 1 = drive |
| reload_i | input | 1 | Load len_i and restart the frame count |
| len_i | input | LEN_W | Frame length in bits |
| irq_clr_i | input | 1 | Write-one-to-clear of the interrupt |
| irq_o | output | 1 | Frame-end interrupt flag |
| tx_wr_i | input | 1 | Push tx_data_i into the transmit queue |
| tx_data_i | input | BYTE_W | Byte to transmit |
| tx_full_o | output | 1 | Transmit queue full |
| rx_rd_i | input | 1 | Pop the receive queue |
| rx_data_o | output | BYTE_W | Oldest received byte |
| rx_empty_o | output | 1 | Receive queue empty |
| ack_o | output | 1 | Last acknowledge bit sampled from the card |
| card_clk_o | output | 1 | Card clock |
| io_o | output | 1 | Data line output value |
| io_oe_o | output | 1 | Data line output enable |
| io_i | input | 1 | Data line input value |

## Verification
All 256 byte values are sent in 8-bit transmit frames and received in 8-bit receive frames. This sweep catches any bit-order or bit-loss error in the shifters. Longer frames use these shapes:
- 16 bits with two bytes queued, which tests the byte boundary.
- 9 bits with two-wire mode off, which tests run-on into a second byte.
- 16 bits with only one byte queued, which tests the all-ones fill.

Two-wire frames of length 9 use both acknowledge values, which separates the acknowledge slot from data slots in both directions. A sweep over every divider value, timing of the clock release, and a frame cut short by a reload check the clock generator and the ownership rules on their own.

// File: rtl/sc_pkg.sv
package sc_pkg;
   // kind of a bit slot inside a frame
   typedef enum logic [1:0] {
      SLOT_TX  = 2'd0,
      SLOT_RX  = 2'd1,
      SLOT_ACK = 2'd2
   } slot_e;
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (W < 1 || DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_cfg
      $error("sc_fifo: DEPTH must be a power of two and W at least 1");
   end

   if (DEPTH == 1) begin : g_one
      logic [W-1:0] d_q;
      logic         v_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_q <= '0;
            v_q <= 1'b0;
         end else if (push && !v_q) begin
            d_q <= din;
            v_q <= 1'b1;
         end else if (pop && v_q) begin
            v_q <= 1'b0;
         end
      end
      assign dout  = d_q;
      assign full  = v_q;
      assign empty = !v_q;
   end else begin : g_ring
      logic [W-1:0]  mem_q [DEPTH];
      logic [AW-1:0] wp_q, rp_q;
      logic [AW:0]   cnt_q;
      logic          do_push, do_pop;

      assign full    = (cnt_q == (AW+1)'(DEPTH));
      assign empty   = (cnt_q == '0);
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;
      assign dout    = mem_q[rp_q];

      always_ff @(posedge clk) begin
         if (do_push) mem_q[wp_q] <= din;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= wp_q + AW'(1);
            if (do_pop)  rp_q <= rp_q + AW'(1);
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
               2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end
endmodule

// File: rtl/sc_clkgen.sv
module sc_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             stop_i,
   input  logic             lvl_i,
   output logic             ck_o,
   output logic             rise_o,
   output logic             fall_o
);
   if (DIV_W < 1) begin : g_bad_cfg
      $error("sc_clkgen: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             ck_q;
   logic             tick;

   assign tick   = !stop_i && (cnt_q == div_i);
   assign rise_o = tick && !ck_q;
   assign fall_o = tick && ck_q;
   assign ck_o   = ck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ck_q  <= 1'b0;
      end else if (stop_i) begin
         cnt_q <= '0;
         ck_q  <= lvl_i;
      end else if (tick) begin
         cnt_q <= '0;
         ck_q  <= !ck_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end
endmodule

// File: rtl/sc_frame.sv
module sc_frame #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             fall_i,
   input  logic             irq_clr_i,
   output logic [LEN_W-1:0] cnt_o,
   output logic [LEN_W-1:0] len_o,
   output logic             run_o,
   output logic             done_o,
   output logic             irq_o
);
   if (LEN_W < 2) begin : g_bad_cfg
      $error("sc_frame: LEN_W must be at least 2");
   end

   logic [LEN_W-1:0] cnt_q, len_q;
   logic             run_q, irq_q, done, step, last;

   assign done = (cnt_q == len_q);
   assign step = fall_i && !reload_i && !done;
   assign last = step && run_q && ((cnt_q + LEN_W'(1)) == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= '0;
         run_q <= 1'b0;
      end else if (reload_i) begin
         cnt_q <= '0;
         len_q <= len_i;
         run_q <= 1'b0;
      end else if (step) begin
         if (!run_q) run_q <= 1'b1;
         else        cnt_q <= cnt_q + LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_q <= 1'b0;
      else if (last)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign len_o  = len_q;
   assign run_o  = run_q;
   assign done_o = done;
   assign irq_o  = irq_q;
endmodule

// File: rtl/sync_card_sequencer.sv
module sync_card_sequencer
   import sc_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int LEN_W      = 6,
   parameter int FIFO_DEPTH = 4,
   parameter int BYTE_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              clk_stop_i,
   input  logic              stop_lvl_i,
   input  logic              tx_mode_i,
   input  logic              twowire_i,
   input  logic              sw_io_i,
   input  logic              sw_dir_i,
   input  logic              reload_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              irq_clr_i,
   output logic              irq_o,
   input  logic              tx_wr_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              tx_full_o,
   input  logic              rx_rd_i,
   output logic [BYTE_W-1:0] rx_data_o,
   output logic              rx_empty_o,
   output logic              ack_o,
   output logic              card_clk_o,
   output logic              io_o,
   output logic              io_oe_o,
   input  logic              io_i
);
   localparam int BCW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

   if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_cfg
      $error("sync_card_sequencer: BYTE_W must be a power of two, at least 2");
   end

   logic             rise_w, fall_w, run_w, done_w, sw_own;
   logic [LEN_W-1:0] cnt_w, len_w, nxt_idx;
   logic             nxt_valid, tx_step, rx_step, ack_step, tx_pop, rx_push;
   logic             tx_empty, rx_full;
   logic [BYTE_W-1:0] tx_head, tx_sh_q, rx_sh_q, rx_byte;
   logic [BCW-1:0]   tx_bc_q, rx_bc_q;
   logic             io_q, ack_q;
   slot_e            cur_kind, nxt_kind;

   function automatic slot_e slot_kind(input logic [LEN_W-1:0] idx,
                                       input logic [LEN_W-1:0] len,
                                       input logic txm, input logic tw);
      if (tw && idx == len - LEN_W'(1)) return SLOT_ACK;
      return txm ? SLOT_TX : SLOT_RX;
   endfunction

   sc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk, .rst_n, .div_i, .stop_i(clk_stop_i), .lvl_i(stop_lvl_i),
      .ck_o(card_clk_o), .rise_o(rise_w), .fall_o(fall_w));

   sc_frame #(.LEN_W(LEN_W)) u_frame (
      .clk, .rst_n, .reload_i, .len_i, .fall_i(fall_w), .irq_clr_i,
      .cnt_o(cnt_w), .len_o(len_w), .run_o(run_w), .done_o(done_w), .irq_o);

   // slot bookkeeping: current slot for sampling, next slot for launching
   assign sw_own    = !run_w || done_w;
   assign cur_kind  = slot_kind(cnt_w, len_w, tx_mode_i, twowire_i);
   assign nxt_idx   = run_w ? cnt_w + LEN_W'(1) : '0;
   assign nxt_valid = !done_w && (nxt_idx < len_w);
   assign nxt_kind  = slot_kind(nxt_idx, len_w, tx_mode_i, twowire_i);

   assign tx_step  = fall_w && !reload_i && nxt_valid && nxt_kind == SLOT_TX;
   assign rx_step  = rise_w && !reload_i && !sw_own && cur_kind == SLOT_RX;
   assign ack_step = rise_w && !reload_i && !sw_own && cur_kind == SLOT_ACK && tx_mode_i;
   assign tx_pop   = tx_step && tx_bc_q == '0 && !tx_empty;
   assign rx_byte  = {io_i, rx_sh_q[BYTE_W-1:1]};
   assign rx_push  = rx_step && rx_bc_q == BCW'(BYTE_W - 1) && !rx_full;

   sc_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk, .rst_n, .push(tx_wr_i), .din(tx_data_i), .pop(tx_pop),
      .dout(tx_head), .full(tx_full_o), .empty(tx_empty));

   sc_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk, .rst_n, .push(rx_push), .din(rx_byte), .pop(rx_rd_i),
      .dout(rx_data_o), .full(rx_full), .empty(rx_empty_o));

   // transmit shifter: launches on the falling card edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q <= '1;
         tx_bc_q <= '0;
         io_q    <= 1'b1;
      end else if (reload_i) begin
         tx_bc_q <= '0;
      end else if (tx_step) begin
         tx_bc_q <= tx_bc_q + BCW'(1);
         if (tx_bc_q != '0) begin
            io_q    <= tx_sh_q[0];
            tx_sh_q <= {1'b1, tx_sh_q[BYTE_W-1:1]};
         end else if (!tx_empty) begin
            io_q    <= tx_head[0];
            tx_sh_q <= {1'b1, tx_head[BYTE_W-1:1]};
         end else begin
            io_q    <= 1'b1;
            tx_sh_q <= '1;
         end
      end
   end

   // receive shifter and acknowledge capture: sample on the rising card edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh_q <= '0;
         rx_bc_q <= '0;
         ack_q   <= 1'b1;
      end else if (reload_i) begin
         rx_bc_q <= '0;
      end else begin
         if (rx_step) begin
            rx_sh_q <= rx_byte;
            rx_bc_q <= rx_bc_q + BCW'(1);
         end
         if (ack_step) ack_q <= io_i;
      end
   end

   assign ack_o = ack_q;

   always_comb begin
      io_o    = sw_io_i;
      io_oe_o = tx_mode_i & sw_dir_i;
      if (!sw_own) begin
         unique case (cur_kind)
            SLOT_TX: begin
               io_o    = io_q;
               io_oe_o = 1'b1;
            end
            SLOT_ACK: begin
               io_o    = 1'b0;
               io_oe_o = !tx_mode_i;
            end
            default: begin
               io_o    = 1'b1;
               io_oe_o = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/sc_checker.sv
module sc_checker (
   input logic clk,
   input logic rst_n,
   input logic clk_stop_i,
   input logic stop_lvl_i,
   input logic card_clk_o,
   input logic irq_o,
   input logic irq_clr_i,
   input logic tx_mode_i,
   input logic twowire_i,
   input logic io_oe_o,
   input logic io_o,
   input logic sw_io_i,
   input logic sw_dir_i,
   input logic reload_i
);
   AST_STOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_i |=> card_clk_o == $past(stop_lvl_i)); // R3

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o); // R6

   AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_mode_i && !twowire_i) |-> !io_oe_o); // R7

   AST_SW_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reload_i) && tx_mode_i) |-> (io_o == sw_io_i && io_oe_o == sw_dir_i)); // R4

   AST_IRQ_NOT_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && clk_stop_i) |=> !irq_o); // R6
endmodule

bind sync_card_sequencer sc_checker u_sc_checker (.*);

// File: tb/sync_card_sequencer_bench.sv
module sync_card_sequencer_bench;
   localparam int DIV_W = 3;
   localparam int LEN_W = 5;
   localparam int DEPTH = 4;
   localparam int BW    = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic [DIV_W-1:0] div_i = '0;
   logic clk_stop_i = 1'b1, stop_lvl_i = 1'b1, tx_mode_i = 1'b0, twowire_i = 1'b0;
   logic sw_io_i = 1'b0, sw_dir_i = 1'b0, reload_i = 1'b0, irq_clr_i = 1'b0;
   logic [LEN_W-1:0] len_i = '0;
   logic tx_wr_i = 1'b0, rx_rd_i = 1'b0, io_i = 1'b1;
   logic [BW-1:0] tx_data_i = '0;
   logic irq_o, tx_full_o, rx_empty_o, ack_o, card_clk_o, io_o, io_oe_o;
   logic [BW-1:0] rx_data_o;

   sync_card_sequencer #(.DIV_W(DIV_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH), .BYTE_W(BW))
   u_sync_card_sequencer (
      .clk, .rst_n, .div_i, .clk_stop_i, .stop_lvl_i, .tx_mode_i, .twowire_i,
      .sw_io_i, .sw_dir_i, .reload_i, .len_i, .irq_clr_i, .irq_o,
      .tx_wr_i, .tx_data_i, .tx_full_o, .rx_rd_i, .rx_data_o, .rx_empty_o,
      .ack_o, .card_clk_o, .io_o, .io_oe_o, .io_i);

   int checks = 0;
   int fails  = 0;
   logic rec_io [32];
   logic rec_oe [32];
   logic drv_pat [32];
   int nr;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic push_byte(input logic [BW-1:0] b);
      @(negedge clk); tx_wr_i = 1'b1; tx_data_i = b;
      @(negedge clk); tx_wr_i = 1'b0;
   endtask

   task automatic pop_rx();
      @(negedge clk); rx_rd_i = 1'b1;
      @(negedge clk); rx_rd_i = 1'b0;
   endtask

   // clock is frozen high here; build the start condition, reload, release
   task automatic start_frame(input int len, input bit txm, input bit tw);
      @(negedge clk); irq_clr_i = 1'b1;
      @(negedge clk); irq_clr_i = 1'b0;
      tx_mode_i = txm; twowire_i = tw; sw_io_i = 1'b0; sw_dir_i = 1'b1;
      len_i = LEN_W'(len); reload_i = 1'b1;
      @(negedge clk); reload_i = 1'b0;
      clk_stop_i = 1'b0; stop_lvl_i = 1'b0;
   endtask

   task automatic run_frame(input int stop_at);
      logic p;
      nr = 0;
      p  = card_clk_o;
      for (int g = 0; g < 4000; g++) begin
         @(negedge clk);
         if (card_clk_o && !p) begin
            if (nr < 32) begin rec_io[nr] = io_o; rec_oe[nr] = io_oe_o; end
            nr++;
         end else if (!card_clk_o && p) begin
            io_i = (nr < 32) ? drv_pat[nr] : 1'b1;
         end
         p = card_clk_o;
         if (irq_o || nr == stop_at) break;
      end
      clk_stop_i = 1'b1; stop_lvl_i = 1'b1;
      @(negedge clk);
   endtask

   function automatic int rec_bits(input int first, input int n);
      int v = 0;
      for (int i = 0; i < n; i++) v = v | (int'(rec_io[first+i]) << i);
      return v;
   endfunction

   function automatic int oe_count(input int n);
      int c = 0;
      for (int i = 0; i < n; i++) c += int'(rec_oe[i]);
      return c;
   endfunction

   task automatic wait_rise(output int n);
      logic p;
      n = 0;
      p = card_clk_o;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         n++;
         if (card_clk_o && !p) break;
         p = card_clk_o;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (R1-R11 run) actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      int n, got;
      for (int i = 0; i < 32; i++) drv_pat[i] = 1'b1;

      // R1 reset state
      repeat (3) @(negedge clk);
      chk(card_clk_o == 1'b0, "R1 card clock in reset", card_clk_o, 0);
      chk(irq_o == 1'b0 && io_oe_o == 1'b0, "R1 irq/oe in reset", {irq_o, io_oe_o}, 0);
      chk(rx_empty_o && !tx_full_o && ack_o, "R1 queue flags/ack in reset",
          {rx_empty_o, tx_full_o, ack_o}, 3'b101);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 divider sweep over every value
      for (int d = 0; d < 8; d++) begin
         clk_stop_i = 1'b1; stop_lvl_i = 1'b1; div_i = DIV_W'(d);
         repeat (2) @(negedge clk);
         clk_stop_i = 1'b0;
         wait_rise(n);
         wait_rise(n);
         chk(n == 2 * (d + 1), "R2 card clock period", n, 2 * (d + 1));
      end

      // R3 freeze level and release timing
      for (int l = 0; l < 2; l++) begin
         clk_stop_i = 1'b1; stop_lvl_i = l[0];
         @(negedge clk);
         chk(card_clk_o == l[0], "R3 frozen level", card_clk_o, l);
         repeat (6) @(negedge clk);
         chk(card_clk_o == l[0], "R3 level held", card_clk_o, l);
      end
      stop_lvl_i = 1'b1; div_i = 3'd2;
      repeat (2) @(negedge clk);
      clk_stop_i = 1'b0;
      n = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); n++;
         if (!card_clk_o) break;
      end
      chk(n == 3, "R3 first transition after release", n, 3);
      clk_stop_i = 1'b1; stop_lvl_i = 1'b1;
      repeat (2) @(negedge clk);

      // R4 software ownership before the frame starts
      tx_mode_i = 1'b1; len_i = 5'd8; reload_i = 1'b1;
      @(negedge clk); reload_i = 1'b0;
      for (int c = 0; c < 4; c++) begin
         sw_io_i = c[0]; sw_dir_i = c[1];
         @(negedge clk);
         chk(io_o == c[0] && io_oe_o == c[1], "R4 software owns line after reload",
             {io_oe_o, io_o}, c);
      end

      // R5 and R6 exhaustive 8-bit transmit frames
      div_i = '0;
      for (int v = 0; v < 256; v++) begin
         push_byte(BW'(v));
         start_frame(8, 1'b1, 1'b0);
         run_frame(99);
         got = rec_bits(0, 8);
         chk(got == v && nr == 8 && oe_count(8) == 8, "R5 byte sent LSB first", got, v);
         chk(irq_o == 1'b1, "R6 irq at frame end", irq_o, 1);
      end

      // R6 sticky until clear; R4 software owns at frame end (stop condition)
      repeat (10) @(negedge clk);
      chk(irq_o == 1'b1, "R6 irq held", irq_o, 1);
      sw_io_i = 1'b0; sw_dir_i = 1'b1;
      @(negedge clk);
      chk(io_o == 1'b0 && io_oe_o == 1'b1, "R4 stop condition low", {io_oe_o, io_o}, 2);
      sw_io_i = 1'b1;
      @(negedge clk);
      chk(io_o == 1'b1 && io_oe_o == 1'b1, "R4 stop condition high", {io_oe_o, io_o}, 3);
      tx_mode_i = 1'b0;
      @(negedge clk);
      chk(io_oe_o == 1'b0, "R7 receive mode releases line", io_oe_o, 0);
      irq_clr_i = 1'b1;
      @(negedge clk); irq_clr_i = 1'b0;
      chk(irq_o == 1'b0, "R6 irq cleared by write-one", irq_o, 1'b0);

      // R5 two-byte frame across the byte boundary
      div_i = 3'd1;
      push_byte(8'hA5); push_byte(8'h3C);
      start_frame(16, 1'b1, 1'b0);
      run_frame(99);
      got = rec_bits(0, 16);
      chk(got == 16'h3CA5 && nr == 16, "R5 16-bit frame", got, 16'h3CA5);

      // R5 9-bit frame with two-wire off runs into the second byte
      push_byte(8'h0F); push_byte(8'hE1);
      start_frame(9, 1'b1, 1'b0);
      run_frame(99);
      got = rec_bits(0, 9);
      chk(got == 9'h10F && oe_count(9) == 9, "R5 9-bit frame all from queue", got, 9'h10F);

      // R11 empty queue gives all ones
      push_byte(8'h5A);
      start_frame(16, 1'b1, 1'b0);
      run_frame(99);
      got = rec_bits(0, 16);
      chk(got == 16'hFF5A, "R11 empty queue fills ones", got, 16'hFF5A);

      // R8 two-wire transmit with both acknowledge values
      for (int a = 0; a < 2; a++) begin
         push_byte(8'hC3);
         drv_pat[8] = a[0];
         start_frame(9, 1'b1, 1'b1);
         run_frame(99);
         got = rec_bits(0, 8);
         chk(got == 8'hC3 && oe_count(8) == 8, "R8 two-wire data slots", got, 8'hC3);
         chk(rec_oe[8] == 1'b0, "R8 ack slot released", rec_oe[8], 0);
         chk(ack_o == a[0], "R8 ack captured", ack_o, a);
      end
      drv_pat[8] = 1'b1;

      // R7 exhaustive 8-bit receive frames
      div_i = '0;
      for (int v = 0; v < 256; v++) begin
         for (int i = 0; i < 8; i++) drv_pat[i] = v[i];
         start_frame(8, 1'b0, 1'b0);
         run_frame(99);
         chk(!rx_empty_o && rx_data_o == BW'(v) && oe_count(8) == 0,
             "R7 byte received LSB first", rx_data_o, v);
         pop_rx();
         chk(rx_empty_o == 1'b1, "R7 queue empty after read", rx_empty_o, 1);
      end

      // R7 two bytes in one frame keep their order
      for (int i = 0; i < 16; i++) drv_pat[i] = ((16'h9617 >> i) & 1) != 0;
      start_frame(16, 1'b0, 1'b0);
      run_frame(99);
      chk(rx_data_o == 8'h17, "R7 first byte of two", rx_data_o, 8'h17);
      pop_rx();
      chk(rx_data_o == 8'h96 && !rx_empty_o, "R7 second byte of two", rx_data_o, 8'h96);
      pop_rx();

      // R9 two-wire receive: block drives acknowledge low, slot not stored
      for (int i = 0; i < 9; i++) drv_pat[i] = ((9'h14B >> i) & 1) != 0;
      start_frame(9, 1'b0, 1'b1);
      run_frame(99);
      chk(rec_oe[8] == 1'b1 && rec_io[8] == 1'b0, "R9 ack driven low",
          {rec_oe[8], rec_io[8]}, 2);
      chk(rx_data_o == 8'h4B && !rx_empty_o, "R9 data byte", rx_data_o, 8'h4B);
      pop_rx();
      chk(rx_empty_o == 1'b1, "R9 ack bit not stored", rx_empty_o, 1);
      for (int i = 0; i < 32; i++) drv_pat[i] = 1'b1;

      // R10 reload mid-frame
      div_i = 3'd1;
      push_byte(8'h81); push_byte(8'h6D);
      start_frame(16, 1'b1, 1'b0);
      run_frame(4);
      chk(nr == 4 && irq_o == 1'b0, "R10 frame cut short without irq", nr, 4);
      sw_io_i = 1'b1; sw_dir_i = 1'b1; len_i = 5'd8; reload_i = 1'b1;
      @(negedge clk); reload_i = 1'b0;
      @(negedge clk);
      chk(io_o == 1'b1 && io_oe_o == 1'b1, "R10 reload returns line to software",
          {io_oe_o, io_o}, 3);
      sw_io_i = 1'b0;
      clk_stop_i = 1'b0; stop_lvl_i = 1'b0;
      run_frame(99);
      got = rec_bits(0, 8);
      chk(got == 8'h6D && nr == 8 && irq_o, "R10 full new frame from fresh byte", got, 8'h6D);

      summary();
      $finish;
   end
endmodule